// File: doc/BRIEF.md
# Micro-op Dispatch Port Scheduler

This block sits between the issue queue of an out-of-order core and its five execution ports. Each cycle it looks at up to `NREQ` micro-op requests, each carrying a class code and an operand-size code. In the same cycle it decides which requests are dispatched and on which port. No port carries more than one micro-op per cycle. Two ports hold ALUs. Port 2 is the load unit. Port 3 computes store addresses and port 4 carries store data. A store takes both of the store ports in the same cycle or takes neither.

Integer and floating-point division each use a divider that is not pipelined. A granted divide issues on port 0 and starts a countdown whose length depends on the operand size. While that countdown runs, no further divide of the same kind is granted. The busy countdowns are held in registers. The grant decision is combinational from the current requests and the busy state. A request that is refused is expected to be presented again by its requester on a later cycle.

Top module: `uop_dispatch_sched`

## Requirements
- R1: In any cycle each of the five ports is given to at most one request. `port_used` bit p is 1 exactly when some granted request occupies port p. Bit 0 is the first ALU port, bit 1 the second ALU port, bit 2 the load port, bit 3 the store-address port and bit 4 the store-data port.
- R2: A request of class 0 (generic ALU) takes port 0 if port 0 is still free. Otherwise it takes port 1 if port 1 is free. Otherwise it is refused. `req_on_p1` is 1 only for a class-0 grant that landed on port 1.
- R3: Class 1 (shift, address generation, multiply, floating point) may use only port 0. Class 2 (branch) may use only port 1. Class 7 is reserved and is never granted.
- R4: Class 3 (load) is granted only on port 2.
- R5: Class 4 (store) is granted only when both port 3 and port 4 are free, and it then occupies both ports in that cycle.
- R6: Requests are served in index order. Index 0 is the oldest and claims its port before any higher index is considered.
- R7: Class 5 (integer divide) needs a free port 0 and an idle integer divider. Once granted, `idiv_busy` is 1 for exactly 12, 21 or 37 cycles after the grant cycle, for size codes 0, 1 or 2 respectively. Size code 3 acts as code 2.
- R8: Class 6 (floating divide) needs a free port 0 and an idle floating divider. Once granted, `fdiv_busy` is 1 for latency minus one cycles after the grant cycle. The latency is 18, 32 or 38 for size codes 0, 1 or 2, and size code 3 acts as code 2.
- R9: At most one divide is granted per cycle, because every divide needs port 0. A divide of one kind may be granted while the divider of the other kind is busy.
- R10: During and straight after a synchronous active-high reset, both busy outputs are 0. With no valid request, no grant is made and `port_used` is 0.
- R11: A refused divide request does not start its divider's busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request present, one bit per slot |
| req_class | input | 3*NREQ | Class code per slot, slot i at bits 3i+2:3i |
| req_size | input | 2*NREQ | Operand-size code per slot, slot i at bits 2i+1:2i |
| req_grant | output | NREQ | Request dispatched this cycle |
| req_on_p1 | output | NREQ | Generic ALU grant placed on port 1 |
| port_used | output | 5 | Ports occupied this cycle |
| idiv_busy | output | 1 | Integer divider still counting |
| fdiv_busy | output | 1 | Floating divider still counting |

## Verification
The assertions take for granted that every input holds a known value from the first clock edge onward. The countdown checks also rely on the divider issue strobe coming only from the arbiter, which already refuses a busy divider. The stimulus changes inputs only on the falling clock edge and starts with reset held for several cycles. It re-presents a refused divide on every cycle of its busy window, so the first cycle in which the divide is accepted pins the window length from both sides.

// File: rtl/uop_sched_pkg.sv
package uop_sched_pkg;

  localparam int NPORT = 5;

  // port indices
  localparam int PT_ALU0 = 0;
  localparam int PT_ALU1 = 1;
  localparam int PT_LD   = 2;
  localparam int PT_STA  = 3;
  localparam int PT_STD  = 4;

  typedef enum logic [2:0] {
    UC_ALU  = 3'd0,
    UC_P0   = 3'd1,
    UC_BR   = 3'd2,
    UC_LD   = 3'd3,
    UC_ST   = 3'd4,
    UC_IDIV = 3'd5,
    UC_FDIV = 3'd6,
    UC_RSVD = 3'd7
  } uop_cls_e;

  typedef logic [NPORT-1:0] port_mask_t;

endpackage

// File: rtl/uop_busy_timer.sv
module uop_busy_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R7 R8: a divider is only started while idle
  a_r7_r8_load_idle: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt == '0));

  // R7 R8: a running window shrinks by one each cycle
  a_r7_r8_countdown: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/uop_port_arbiter.sv
module uop_port_arbiter
  import uop_sched_pkg::*;
#(
  parameter int NREQ = 4
) (
  input  logic [NREQ-1:0]            valid,
  input  uop_cls_e [NREQ-1:0]        cls,
  input  logic [NREQ-1:0][1:0]       size,
  input  logic                       idiv_busy,
  input  logic                       fdiv_busy,
  output logic [NREQ-1:0]            grant,
  output logic [NREQ-1:0]            on_p1,
  output port_mask_t [NREQ-1:0]      mask,
  output port_mask_t                 used,
  output logic                       idiv_go,
  output logic [1:0]                 idiv_sz,
  output logic                       fdiv_go,
  output logic [1:0]                 fdiv_sz
);

  always_comb begin
    port_mask_t taken;
    logic       idiv_claim;
    logic       fdiv_claim;
    taken      = '0;
    idiv_claim = idiv_busy;
    fdiv_claim = fdiv_busy;
    idiv_go    = 1'b0;
    fdiv_go    = 1'b0;
    idiv_sz    = 2'd0;
    fdiv_sz    = 2'd0;
    for (int i = 0; i < NREQ; i++) begin
      mask[i]  = '0;
      on_p1[i] = 1'b0;
      if (valid[i]) begin
        unique case (cls[i])
          UC_ALU: begin
            if (!taken[PT_ALU0])
              mask[i][PT_ALU0] = 1'b1;
            else if (!taken[PT_ALU1]) begin
              mask[i][PT_ALU1] = 1'b1;
              on_p1[i]         = 1'b1;
            end
          end
          UC_P0:
            if (!taken[PT_ALU0]) mask[i][PT_ALU0] = 1'b1;
          UC_BR:
            if (!taken[PT_ALU1]) mask[i][PT_ALU1] = 1'b1;
          UC_LD:
            if (!taken[PT_LD]) mask[i][PT_LD] = 1'b1;
          UC_ST:
            if (!taken[PT_STA] && !taken[PT_STD]) begin
              mask[i][PT_STA] = 1'b1;
              mask[i][PT_STD] = 1'b1;
            end
          UC_IDIV:
            if (!taken[PT_ALU0] && !idiv_claim) begin
              mask[i][PT_ALU0] = 1'b1;
              idiv_claim       = 1'b1;
              idiv_go          = 1'b1;
              idiv_sz          = size[i];
            end
          UC_FDIV:
            if (!taken[PT_ALU0] && !fdiv_claim) begin
              mask[i][PT_ALU0] = 1'b1;
              fdiv_claim       = 1'b1;
              fdiv_go          = 1'b1;
              fdiv_sz          = size[i];
            end
          default: ;
        endcase
      end
      grant[i] = |mask[i];
      taken    = taken | mask[i];
    end
    used = taken;
  end

endmodule

// File: rtl/uop_dispatch_sched.sv
module uop_dispatch_sched
  import uop_sched_pkg::*;
#(
  parameter int NREQ       = 4,
  parameter int IDIV_CYC_B = 12,
  parameter int IDIV_CYC_H = 21,
  parameter int IDIV_CYC_W = 37,
  parameter int FDIV_LAT_S = 18,
  parameter int FDIV_LAT_D = 32,
  parameter int FDIV_LAT_X = 38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREQ-1:0]   req_valid,
  input  logic [3*NREQ-1:0] req_class,
  input  logic [2*NREQ-1:0] req_size,
  output logic [NREQ-1:0]   req_grant,
  output logic [NREQ-1:0]   req_on_p1,
  output logic [NPORT-1:0]  port_used,
  output logic              idiv_busy,
  output logic              fdiv_busy
);

  localparam int MAX_I  = (IDIV_CYC_W > IDIV_CYC_H) ?
                          ((IDIV_CYC_W > IDIV_CYC_B) ? IDIV_CYC_W : IDIV_CYC_B) :
                          ((IDIV_CYC_H > IDIV_CYC_B) ? IDIV_CYC_H : IDIV_CYC_B);
  localparam int MAX_F  = (FDIV_LAT_X > FDIV_LAT_D) ?
                          ((FDIV_LAT_X > FDIV_LAT_S) ? FDIV_LAT_X : FDIV_LAT_S) :
                          ((FDIV_LAT_D > FDIV_LAT_S) ? FDIV_LAT_D : FDIV_LAT_S);
  localparam int MAX_C  = (MAX_I > MAX_F) ? MAX_I : MAX_F;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  uop_cls_e [NREQ-1:0]      cls;
  logic [NREQ-1:0][1:0]     sz;
  port_mask_t [NREQ-1:0]    mask;
  logic                     idiv_go, fdiv_go;
  logic [1:0]               idiv_sz, fdiv_sz;
  logic [CNT_W-1:0]         idiv_len, fdiv_len;

  for (genvar i = 0; i < NREQ; i++) begin : g_unpack
    assign cls[i] = uop_cls_e'(req_class[3*i +: 3]);
    assign sz[i]  = req_size[2*i +: 2];
  end

  uop_port_arbiter #(.NREQ(NREQ)) u_arb (
    .valid     (req_valid),
    .cls       (cls),
    .size      (sz),
    .idiv_busy (idiv_busy),
    .fdiv_busy (fdiv_busy),
    .grant     (req_grant),
    .on_p1     (req_on_p1),
    .mask      (mask),
    .used      (port_used),
    .idiv_go   (idiv_go),
    .idiv_sz   (idiv_sz),
    .fdiv_go   (fdiv_go),
    .fdiv_sz   (fdiv_sz)
  );

  always_comb begin
    unique case (idiv_sz)
      2'd0:    idiv_len = CNT_W'(IDIV_CYC_B);
      2'd1:    idiv_len = CNT_W'(IDIV_CYC_H);
      default: idiv_len = CNT_W'(IDIV_CYC_W);
    endcase
    unique case (fdiv_sz)
      2'd0:    fdiv_len = CNT_W'(FDIV_LAT_S - 1);
      2'd1:    fdiv_len = CNT_W'(FDIV_LAT_D - 1);
      default: fdiv_len = CNT_W'(FDIV_LAT_X - 1);
    endcase
  end

  uop_busy_timer #(.CNT_W(CNT_W)) u_idiv_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (idiv_go),
    .load_val (idiv_len),
    .busy     (idiv_busy)
  );

  uop_busy_timer #(.CNT_W(CNT_W)) u_fdiv_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (fdiv_go),
    .load_val (fdiv_len),
    .busy     (fdiv_busy)
  );

  // R1: no port is handed to two requests
  for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
    logic [NREQ-1:0] col;
    for (genvar i = 0; i < NREQ; i++) begin : g_col
      assign col[i] = mask[i][p];
    end
    a_r1_single_owner: assert property (@(posedge clk) disable iff (rst)
      $countones(col) <= 1);
  end

  // R5: a granted store holds both store ports
  for (genvar i = 0; i < NREQ; i++) begin : g_st_chk
    a_r5_store_pair: assert property (@(posedge clk) disable iff (rst)
      (req_grant[i] && cls[i] == UC_ST) |-> (mask[i][PT_STA] && mask[i][PT_STD]));
  end

  // R7: integer divide only when its unit is idle
  a_r7_idiv_idle: assert property (@(posedge clk) disable iff (rst)
    idiv_go |-> !idiv_busy);

  // R8: floating divide only when its unit is idle
  a_r8_fdiv_idle: assert property (@(posedge clk) disable iff (rst)
    fdiv_go |-> !fdiv_busy);

  // R9: divides share port 0, so never two in one cycle
  a_r9_one_divide: assert property (@(posedge clk) disable iff (rst)
    !(idiv_go && fdiv_go));

endmodule

// File: tb/test_uop_dispatch_sched.sv
module test_uop_dispatch_sched;

  localparam int NREQ = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NREQ-1:0]   req_valid = '0;
  logic [3*NREQ-1:0] req_class = '0;
  logic [2*NREQ-1:0] req_size  = '0;
  logic [NREQ-1:0]   req_grant, req_on_p1;
  logic [4:0]        port_used;
  logic              idiv_busy, fdiv_busy;

  always #2.5 clk = ~clk;

  uop_dispatch_sched #(.NREQ(NREQ)) i_uop_dispatch_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .req_size(req_size), .req_grant(req_grant), .req_on_p1(req_on_p1),
    .port_used(port_used), .idiv_busy(idiv_busy), .fdiv_busy(fdiv_busy)
  );

  typedef struct {
    logic [3:0] g;
    logic [3:0] p1;
    logic [4:0] u;
    logic       ib;
    logic       fb;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  int   ileft  = 0;
  int   fleft  = 0;
  bit   done   = 0;

  logic [NREQ-1:0] st_v;
  logic [2:0]      st_c [NREQ];
  logic [1:0]      st_s [NREQ];

  // class codes as stated in the requirements
  localparam logic [2:0] C_ALU = 3'd0, C_P0 = 3'd1, C_BR = 3'd2, C_LD = 3'd3,
                         C_ST = 3'd4, C_IDIV = 3'd5, C_FDIV = 3'd6, C_RSVD = 3'd7;

  task automatic clear_req();
    st_v = '0;
    for (int i = 0; i < NREQ; i++) begin
      st_c[i] = 3'd0;
      st_s[i] = 2'd0;
    end
  endtask

  task automatic set_req(input int i, input logic [2:0] c, input logic [1:0] s);
    st_v[i] = 1'b1;
    st_c[i] = c;
    st_s[i] = s;
  endtask

  // driver: apply staged request set, push expected outcome
  task automatic step(input logic [3:0] eg, input logic [3:0] ep1, input logic [4:0] eu,
                      input bit iiss, input int in, input bit fiss, input int fn,
                      input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = st_v;
    for (int i = 0; i < NREQ; i++) begin
      req_class[3*i +: 3] = st_c[i];
      req_size[2*i +: 2]  = st_s[i];
    end
    e.g = eg; e.p1 = ep1; e.u = eu;
    e.ib = (ileft != 0);
    e.fb = (fleft != 0);
    e.tag = tag;
    q.push_back(e);
    if (iiss) ileft = in; else if (ileft > 0) ileft--;
    if (fiss) fleft = fn; else if (fleft > 0) fleft--;
  endtask

  task automatic idle(input int n, input string tag);
    clear_req();
    for (int k = 0; k < n; k++) step(4'b0, 4'b0, 5'b0, 0, 0, 0, 0, tag);
  endtask

  // issue a divide, hold it during the window, see it accepted right after
  task automatic div_window(input logic [2:0] c, input logic [1:0] s, input int n,
                            input string tag);
    bit isi;
    isi = (c == C_IDIV);
    clear_req(); set_req(0, c, s);
    step(4'b0001, 4'b0, 5'b00001, isi, n, !isi, n, {tag, " issue"});
    for (int k = 0; k < n; k++) begin
      clear_req(); set_req(0, c, s); set_req(1, C_ALU, 2'd0);
      step(4'b0010, 4'b0, 5'b00001, 0, 0, 0, 0, {tag, " held while busy"});
    end
    clear_req(); set_req(0, c, s); set_req(1, C_ALU, 2'd0);
    step(4'b0011, 4'b0010, 5'b00011, isi, n, !isi, n, {tag, " accepted after window"});
    idle(n + 1, {tag, " drain"});
  endtask

  // monitor: compare between edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (req_grant !== e.g || req_on_p1 !== e.p1 || port_used !== e.u ||
            idiv_busy !== e.ib || fdiv_busy !== e.fb) begin
          errors++;
          $display("FAIL %s: got g=%b p1=%b u=%b ib=%b fb=%b exp g=%b p1=%b u=%b ib=%b fb=%b",
                   e.tag, req_grant, req_on_p1, port_used, idiv_busy, fdiv_busy,
                   e.g, e.p1, e.u, e.ib, e.fb);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_req();
    repeat (4) @(posedge clk);
    // R10: busy low and nothing granted while reset is held
    step(4'b0, 4'b0, 5'b0, 0, 0, 0, 0, "R10 in reset");
    @(negedge clk);
    rst = 1'b0;
    idle(2, "R10 after reset");

    // R2: lone ALU on port 0
    clear_req(); set_req(0, C_ALU, 0);
    step(4'b0001, 4'b0, 5'b00001, 0, 0, 0, 0, "R2 alu port0");
    // R2: ALU falls to port 1
    clear_req(); set_req(0, C_P0, 0); set_req(1, C_ALU, 0);
    step(4'b0011, 4'b0010, 5'b00011, 0, 0, 0, 0, "R2 alu port1");
    // R2 R3: both ALU ports taken, ALU refused
    clear_req(); set_req(0, C_P0, 0); set_req(1, C_BR, 0); set_req(2, C_ALU, 0);
    step(4'b0011, 4'b0, 5'b00011, 0, 0, 0, 0, "R2 alu refused");
    // R3 R6: two branches, older wins
    clear_req(); set_req(0, C_BR, 0); set_req(1, C_BR, 0);
    step(4'b0001, 4'b0, 5'b00010, 0, 0, 0, 0, "R3 branch port1 only");
    // R3: reserved class never granted
    clear_req(); set_req(0, C_RSVD, 0); set_req(1, C_RSVD, 2);
    step(4'b0, 4'b0, 5'b0, 0, 0, 0, 0, "R3 reserved class");
    // R6: older ALU takes port 0, younger port-0-only refused
    clear_req(); set_req(0, C_ALU, 0); set_req(1, C_P0, 0);
    step(4'b0001, 4'b0, 5'b00001, 0, 0, 0, 0, "R6 priority");
    // R4 R5: load, store, second store refused, ALU
    clear_req(); set_req(0, C_LD, 0); set_req(1, C_ST, 0); set_req(2, C_ST, 0);
    set_req(3, C_ALU, 0);
    step(4'b1011, 4'b0, 5'b11101, 0, 0, 0, 0, "R5 store pair");
    // R4: two loads, one granted
    clear_req(); set_req(0, C_LD, 0); set_req(1, C_LD, 0);
    step(4'b0001, 4'b0, 5'b00100, 0, 0, 0, 0, "R4 load port2");
    // R1: all five ports in one cycle
    clear_req(); set_req(0, C_ALU, 0); set_req(1, C_ALU, 0); set_req(2, C_LD, 0);
    set_req(3, C_ST, 0);
    step(4'b1111, 4'b0010, 5'b11111, 0, 0, 0, 0, "R1 full dispatch");

    // R11: refused divide starts no window
    clear_req(); set_req(0, C_P0, 0); set_req(1, C_IDIV, 0);
    step(4'b0001, 4'b0, 5'b00001, 0, 0, 0, 0, "R11 refused idiv");
    clear_req(); set_req(0, C_BR, 0); set_req(1, C_FDIV, 0); set_req(2, C_FDIV, 1);
    step(4'b0011, 4'b0, 5'b00011, 0, 0, 1, 17, "R11 second fdiv refused");
    idle(18, "R11 drain");

    // R7 windows
    div_window(C_IDIV, 2'd0, 12, "R7 idiv byte");
    div_window(C_IDIV, 2'd1, 21, "R7 idiv half");
    div_window(C_IDIV, 2'd2, 37, "R7 idiv word");
    div_window(C_IDIV, 2'd3, 37, "R7 idiv code3");
    // R8 windows
    div_window(C_FDIV, 2'd0, 17, "R8 fdiv single");
    div_window(C_FDIV, 2'd1, 31, "R8 fdiv double");
    div_window(C_FDIV, 2'd2, 37, "R8 fdiv extended");
    div_window(C_FDIV, 2'd3, 37, "R8 fdiv code3");

    // R9: fdiv and idiv in one cycle, older wins; idiv then runs alongside
    clear_req(); set_req(0, C_FDIV, 0); set_req(1, C_IDIV, 0);
    step(4'b0001, 4'b0, 5'b00001, 0, 0, 1, 17, "R9 one divide per cycle");
    clear_req(); set_req(0, C_IDIV, 1);
    step(4'b0001, 4'b0, 5'b00001, 1, 21, 0, 0, "R9 idiv while fdiv busy");
    idle(23, "R9 drain");

    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule